// File: doc/BRIEF.md
# Exact Unrounded Floating-Point Multiplier

This block takes two binary floating-point operands with an `EXP_W`-bit biased exponent and an `FRAC_W`-bit fraction, and returns their product with no rounding and no normalization. The result uses a widened format: an `EXP_W+1`-bit exponent and a `2*FRAC_W+2`-bit mantissa that holds every bit of the product of the two significands. With the default single-width operands, that mantissa is 48 bits.

The output is meant to go straight into a wide fixed-point accumulator. That consumer aligns the mantissa by shifting it according to the exponent, so a normalization step here would add logic and gain nothing. Because no bit is dropped, the product carries no rounding error.

Operands with a zero exponent field are treated as zero, and subnormal fractions are discarded. Operands with an all-ones exponent field are flagged as special and are not otherwise processed. The block accepts a new operand pair every cycle, and each result appears two cycles after its operands.

Top module: `exact_fp_mult`

## Requirements
- R1: A result is presented with `out_valid` high exactly two clock cycles after `in_valid` was high. `out_valid` is low two cycles after `in_valid` was low.
- R2: For two nonzero operands, `out_mant` equals the integer product of `{1, frac_a}` and `{1, frac_b}`, each `FRAC_W+1` bits wide, over the full `2*FRAC_W+2` bits. The result is not shifted, so at least one of its two top bits is set.
- R3: For two nonzero operands, `out_exp` equals `exp_a + exp_b - 2*(2^(EXP_W-1)-1) + (2^EXP_W-1)`, which is `exp_a + exp_b + 1`. This value always fits the `EXP_W+1`-bit field and is never zero or all ones.
- R4: `out_sign` is the XOR of the two operand sign bits, which sit at the MSB of each operand. This holds for every input, zero operands included.
- R5: If either operand's exponent field is all zeros, `out_mant` and `out_exp` are both zero and `out_zero` is 1, whatever the fraction bits hold.
- R6: If either operand's exponent field is all ones, `out_special` is 1. Otherwise it is 0.
- R7: While `rst_n` is low and in the first cycle after it rises, `out_valid` is 0 and all data outputs are 0.
- R8: Operand pairs presented on consecutive cycles each produce their own correct result on consecutive cycles, with no stall.
- R9: Operand layout is sign at the MSB, then `EXP_W` exponent bits, then `FRAC_W` fraction bits at the LSBs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| op_a | input | EXP_W+FRAC_W+1 | First operand |
| op_b | input | EXP_W+FRAC_W+1 | Second operand |
| out_valid | output | 1 | Result is valid |
| out_sign | output | 1 | Product sign |
| out_exp | output | EXP_W+1 | Widened biased exponent |
| out_mant | output | 2*FRAC_W+2 | Full unnormalized product mantissa |
| out_zero | output | 1 | An operand was zero or subnormal |
| out_special | output | 1 | An operand had an all-ones exponent |

## Verification
The bench drives operands whose fractions are all ones, so the product fills the top mantissa bit. A design that truncated or narrowed the multiplier would lose high or low bits there. It also drives pairs of 1.0, so the product lands exactly on the lower leading-bit position. A design that normalized the mantissa would shift that result and move the exponent.

The exponent extremes 1 and 2^EXP_W-2 are exercised. A design that used the wrong bias correction, or too narrow an exponent sum, would wrap or go off by the bias there.

Zero exponents paired with nonzero fractions are checked. A design that kept the implicit one for such operands would produce a nonzero mantissa. Long back-to-back random streams with gaps expose any valid or data misalignment in the two-stage pipeline.

// File: rtl/exact_fp_mult.sv
module exact_fp_mult #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [EXP_W+FRAC_W:0]      op_a,
  input  logic [EXP_W+FRAC_W:0]      op_b,
  output logic                       out_valid,
  output logic                       out_sign,
  output logic [EXP_W:0]             out_exp,
  output logic [2*FRAC_W+1:0]        out_mant,
  output logic                       out_zero,
  output logic                       out_special
);

  localparam int MW       = FRAC_W + 1;
  localparam int PW       = 2 * MW;
  localparam int XW       = EXP_W + 1;
  localparam int BIAS_IN  = (1 << (EXP_W - 1)) - 1;
  localparam int BIAS_OUT = (1 << EXP_W) - 1;
  localparam logic [XW-1:0] EXP_OFS = XW'(BIAS_OUT - 2 * BIAS_IN);

  // R9: field positions
  logic [EXP_W-1:0] ea, eb;
  logic             za, zb;
  logic             sign_c, zero_c;

  assign ea     = op_a[EXP_W+FRAC_W-1:FRAC_W];
  assign eb     = op_b[EXP_W+FRAC_W-1:FRAC_W];
  assign za     = (ea == '0);
  assign zb     = (eb == '0);
  assign zero_c = za | zb;
  assign sign_c = op_a[EXP_W+FRAC_W] ^ op_b[EXP_W+FRAC_W];

  logic          s1_v, s1_sign, s1_zero, s1_spec;
  logic [XW-1:0] s1_exp;
  logic [MW-1:0] s1_ma, s1_mb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_sign <= 1'b0;
      s1_zero <= 1'b0;
      s1_spec <= 1'b0;
      s1_exp  <= '0;
      s1_ma   <= '0;
      s1_mb   <= '0;
    end else begin
      s1_v    <= in_valid;
      s1_sign <= sign_c;
      s1_zero <= zero_c;
      s1_spec <= (&ea) | (&eb);
      s1_exp  <= zero_c ? '0 : XW'(ea) + XW'(eb) + EXP_OFS;
      s1_ma   <= za ? '0 : {1'b1, op_a[FRAC_W-1:0]};
      s1_mb   <= zb ? '0 : {1'b1, op_b[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_mant    <= '0;
      out_zero    <= 1'b0;
      out_special <= 1'b0;
    end else begin
      out_valid   <= s1_v;
      out_sign    <= s1_sign;
      out_exp     <= s1_exp;
      out_mant    <= PW'(s1_ma) * PW'(s1_mb);
      out_zero    <= s1_zero;
      out_special <= s1_spec;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##2 out_valid); // R1
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |-> ##2 !out_valid); // R1
  AST_MANT_LEAD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_zero) |-> (out_mant[PW-1:PW-2] != 2'b00)); // R2
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_zero && !out_special) |-> (out_exp != '0 && out_exp != '1)); // R3
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##2 (out_sign == $past(op_a[EXP_W+FRAC_W] ^ op_b[EXP_W+FRAC_W], 2))); // R4
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_zero) |-> (out_mant == '0 && out_exp == '0)); // R5

endmodule

// File: tb/sim_exact_fp_mult.sv
module sim_exact_fp_mult;
  localparam int E  = 8;
  localparam int F  = 23;
  localparam int OW = E + F + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [OW-1:0] op_a = '0, op_b = '0;
  logic out_valid, out_sign, out_zero, out_special;
  logic [E:0] out_exp;
  logic [2*F+1:0] out_mant;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exact_fp_mult #(.EXP_W(E), .FRAC_W(F)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_mant(out_mant), .out_zero(out_zero), .out_special(out_special)
  );

  always #2 clk = ~clk;

  // expectation pipeline: index 0 newest
  bit      pv[2];
  bit      psg[2], pz[2], psp[2];
  longint  pex[2];
  longint  pm[2];

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [OW-1:0] a, logic [OW-1:0] b);
    longint ea, eb, ma, mb;
    bit z;
    @(negedge clk);
    check("R1 valid", longint'(out_valid), longint'(pv[1]));
    if (pv[1]) begin
      check("R2 mantissa", longint'(out_mant), pm[1]);
      check("R3 exponent", longint'(out_exp), pex[1]);
      check("R4 sign", longint'(out_sign), longint'(psg[1]));
      check("R5 zero flag", longint'(out_zero), longint'(pz[1]));
      check("R6 special flag", longint'(out_special), longint'(psp[1]));
    end
    pv[1] = pv[0]; psg[1] = psg[0]; pz[1] = pz[0]; psp[1] = psp[0];
    pex[1] = pex[0]; pm[1] = pm[0];
    ea = longint'(a[OW-2:F]);
    eb = longint'(b[OW-2:F]);
    ma = (longint'(1) << F) | longint'(a[F-1:0]);
    mb = (longint'(1) << F) | longint'(b[F-1:0]);
    z  = (ea == 0) || (eb == 0);
    pv[0]  = v;
    psg[0] = a[OW-1] ^ b[OW-1];
    pz[0]  = z;
    psp[0] = (ea == (1 << E) - 1) || (eb == (1 << E) - 1);
    pex[0] = z ? 0 : ea + eb - 2 * ((1 << (E - 1)) - 1) + ((1 << E) - 1);
    pm[0]  = z ? 0 : ma * mb;
    in_valid = v; op_a = a; op_b = b;
  endtask

  function automatic logic [OW-1:0] mk(bit s, int e, int f);
    return {s, e[E-1:0], f[F-1:0]};
  endfunction

  initial begin
    void'($urandom(32'd2718));
    pv[0] = 0; pv[1] = 0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset valid", longint'(out_valid), 0);
    check("R7 reset mant", longint'(out_mant), 0);
    check("R7 reset exp", longint'(out_exp), 0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R7 after release", longint'(out_valid), 0);
    // directed corners (R2 R3 R5 R6 R8 R9)
    step(1, mk(0, 127, 0), mk(0, 127, 0));
    step(1, mk(1, 200, 32'h7fffff), mk(0, 100, 32'h7fffff));
    step(1, mk(0, 1, 0), mk(1, 1, 5));
    step(1, mk(1, 254, 32'h7fffff), mk(1, 254, 32'h400000));
    step(1, mk(0, 0, 32'h12345), mk(0, 130, 7));
    step(1, mk(1, 140, 9), mk(0, 0, 0));
    step(1, mk(0, 255, 0), mk(0, 127, 0));
    step(0, mk(0, 5, 5), mk(0, 5, 5));
    step(1, mk(0, 255, 1), mk(1, 0, 3));
    step(0, '0, '0);
    // random stream with gaps (R8)
    for (int i = 0; i < 3000; i++) begin
      logic [OW-1:0] ra, rb;
      ra = OW'($urandom);
      rb = OW'($urandom);
      if ($urandom_range(0, 15) == 0) ra[OW-2:F] = '0;
      if ($urandom_range(0, 15) == 0) rb[OW-2:F] = '1;
      step($urandom_range(0, 4) != 0, ra, rb);
    end
    step(0, '0, '0);
    step(0, '0, '0);
    step(0, '0, '0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule